// File: doc/BRIEF.md
# Ingress Broadcast Storm Filter

This block gives one switch port's receive path a forward-or-drop decision for every completed frame. When the receive logic finishes a frame it pulses a frame-end strobe together with the frame's destination MAC address, a CRC-good flag and the byte length. One clock later the block returns a verdict pulse that says whether the frame is dropped and, if so, why.

Three rules produce the verdict. Frames that are malformed (bad CRC or an illegal length) are discarded. Frames addressed to the reserved bridge group range are dropped either always or only under a strap, depending on the last address byte. Runs of broadcast frames are limited by a saturating counter. A non-broadcast frame clears the counter, and so does a periodic window tick from a parameterised prescaler. Three configuration straps are sampled while reset is held low and stay fixed until the next reset.

Top module: `ingress_frame_gate`

## Requirements
- R1: For each cycle with `frm_end` high, `verdict_valid` is high on the following cycle. `verdict_valid` is low in every other cycle. A frame that no rule rejects gets `verdict_drop`=0 and `verdict_cause`=0.
- R2: With storm limiting enabled, the first BURST_LIMIT (default 64) broadcast frames (destination FF-FF-FF-FF-FF-FF) in a row are forwarded. Every further broadcast frame is dropped with cause 3.
- R3: A legal frame whose destination is not broadcast clears the broadcast run count. This holds even if the frame itself is dropped as a reserved group frame.
- R4: Every WINDOW_CYCLES clock cycles after reset the run count returns to zero. A broadcast frame that ends in the same cycle as the tick is counted as the first of a new run.
- R5: When the storm strap was low at reset, broadcast frames are never dropped with cause 3.
- R6: Destinations 01-80-C2-00-00-01 and 01-80-C2-00-00-02 are always dropped with cause 2.
- R7: Destinations 01-80-C2-00-00-03 to 01-80-C2-00-00-0F are dropped with cause 2 only when the control strap was high at reset, and are forwarded otherwise. The neighbours ...-00 and ...-10 are never dropped by this rule.
- R8: A frame with a bad CRC is dropped with cause 1 unless the accept-error strap was high at reset.
- R9: A frame shorter than 64 bytes or longer than 1536 bytes is dropped with cause 1 whatever the accept-error strap says. Lengths of exactly 64 and 1536 are legal.
- R10: A frame dropped with cause 1 leaves the run count unchanged. Cause priority is 1 over 2 over 3.
- R11: Strap inputs are captured while `rst_n` is low. Changes to them after reset has been released have no effect.
- R12: During reset and in the cycle after it, `verdict_valid`, `verdict_drop` and `verdict_cause` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; straps are sampled while low |
| strap_storm_en | input | 1 | Enables broadcast run limiting |
| strap_ctrl_drop | input | 1 | Enables dropping of the optional reserved group addresses |
| strap_accept_err | input | 1 | Lets bad-CRC frames of legal length through |
| frm_end | input | 1 | One-cycle strobe at the end of a received frame |
| frm_da | input | 48 | Destination MAC address, first transmitted byte in bits 47:40 |
| frm_crc_ok | input | 1 | High when the frame CRC was good |
| frm_len | input | LEN_W | Frame length in bytes |
| verdict_valid | output | 1 | One-cycle pulse carrying the decision |
| verdict_drop | output | 1 | High when the frame is to be discarded |
| verdict_cause | output | 2 | Drop cause: 0 none, 1 illegal, 2 reserved group, 3 storm |

## Verification
The assertions assume that `frm_end` is a single-cycle strobe. They also assume that the address, CRC flag and length are stable and meaningful in that cycle, and that straps have settled before reset is released. The stimulus drives every frame on a falling edge, holds the strobe for exactly one cycle and reads the verdict at the next falling edge. It changes straps only while reset is low, except in the one scenario that checks that post-reset changes are ignored. Runs of broadcasts are kept well inside one window period measured from reset, so window ticks only occur where a scenario waits for one on purpose.

// File: rtl/gate_pkg.sv
// Shared types and constants for the ingress frame gate.
// Assumes MAC addresses are presented with the first transmitted byte in bits 47:40.
package gate_pkg;
    typedef enum logic [1:0] {
        CAUSE_NONE     = 2'd0,
        CAUSE_ILLEGAL  = 2'd1,
        CAUSE_RESERVED = 2'd2,
        CAUSE_STORM    = 2'd3
    } drop_cause_e;

    localparam logic [47:0] BCAST_DA  = 48'hFFFF_FFFF_FFFF;
    localparam logic [39:0] RESV_PREF = 40'h01_80C2_0000;
endpackage

// File: rtl/window_ticker.sv
// Free-running prescaler that raises tick for one cycle every PERIOD cycles.
// Assumes PERIOD >= 2; the first tick comes PERIOD cycles after reset release.
module window_ticker #(
    parameter int unsigned PERIOD = 40_000_000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int unsigned CW = $clog2(PERIOD);
    localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

    logic [CW-1:0] cnt;

    // Count cycles, wrapping at the end of each window.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (cnt == LAST) cnt <= '0;
        else                  cnt <= cnt + 1'b1;
    end

    assign tick = (cnt == LAST);

    p_tick_isolated_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/frame_classifier.sv
// Combinational decode of one frame's address, CRC flag and length.
// Assumes inputs are meaningful only while the frame-end strobe is high.
module frame_classifier #(
    parameter int unsigned LEN_W   = 12,
    parameter int unsigned MIN_LEN = 64,
    parameter int unsigned MAX_LEN = 1536
) (
    input  logic [47:0]      da,
    input  logic             crc_ok,
    input  logic [LEN_W-1:0] len,
    input  logic             accept_err,
    input  logic             ctrl_drop,
    output logic             is_bcast,
    output logic             illegal,
    output logic             resv_drop
);
    import gate_pkg::*;

    logic len_ok, in_resv, fixed_hit, opt_hit;

    // Classify the frame against the length, CRC and reserved-address rules.
    always_comb begin
        len_ok    = (len >= LEN_W'(MIN_LEN)) && (len <= LEN_W'(MAX_LEN));
        illegal   = !len_ok || (!crc_ok && !accept_err);
        is_bcast  = (da == BCAST_DA);
        in_resv   = (da[47:8] == RESV_PREF);
        fixed_hit = in_resv && ((da[7:0] == 8'h01) || (da[7:0] == 8'h02));
        opt_hit   = in_resv && (da[7:0] >= 8'h03) && (da[7:0] <= 8'h0F);
        resv_drop = fixed_hit || (opt_hit && ctrl_drop);
    end
endmodule

// File: rtl/storm_counter.sv
// Saturating count of consecutive legal broadcast frames.
// Assumes frame_seen is high only for frames that passed the legality check.
module storm_counter #(
    parameter int unsigned LIMIT = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_seen,
    input  logic is_bcast,
    input  logic tick,
    output logic over_limit
);
    localparam int unsigned CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] TOP = CW'(LIMIT);

    logic [CW-1:0] cnt, base;

    // The window tick clears the run before the current frame is applied.
    always_comb begin
        base       = tick ? '0 : cnt;
        over_limit = (base == TOP);
    end

    // Advance, clear or hold the run count.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (frame_seen && is_bcast)
            cnt <= (base == TOP) ? TOP : base + 1'b1;
        else if (frame_seen)
            cnt <= '0;
        else
            cnt <= base;
    end

    p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= TOP);
    p_nonbc_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_seen && !is_bcast) |=> (cnt == '0));
    p_tick_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !frame_seen) |=> (cnt == '0));
    p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_seen && !tick) |=> $stable(cnt));
endmodule

// File: rtl/ingress_frame_gate.sv
// Per-port forward/drop decision for each received frame.
// Assumes frm_end is a one-cycle strobe and straps are stable while rst_n is low.
module ingress_frame_gate #(
    parameter int unsigned LEN_W         = 12,
    parameter int unsigned MIN_LEN       = 64,
    parameter int unsigned MAX_LEN       = 1536,
    parameter int unsigned BURST_LIMIT   = 64,
    parameter int unsigned WINDOW_CYCLES = 40_000_000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strap_storm_en,
    input  logic             strap_ctrl_drop,
    input  logic             strap_accept_err,
    input  logic             frm_end,
    input  logic [47:0]      frm_da,
    input  logic             frm_crc_ok,
    input  logic [LEN_W-1:0] frm_len,
    output logic             verdict_valid,
    output logic             verdict_drop,
    output logic [1:0]       verdict_cause
);
    import gate_pkg::*;

    logic        cfg_storm, cfg_ctrl, cfg_accept;
    logic        is_bcast, illegal, resv_drop, tick, over_limit;
    drop_cause_e cause_d;

    // Sample the straps throughout reset; hold them afterwards.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_storm  <= strap_storm_en;
            cfg_ctrl   <= strap_ctrl_drop;
            cfg_accept <= strap_accept_err;
        end
    end

    frame_classifier #(.LEN_W(LEN_W), .MIN_LEN(MIN_LEN), .MAX_LEN(MAX_LEN)) u_class (
        .da(frm_da), .crc_ok(frm_crc_ok), .len(frm_len),
        .accept_err(cfg_accept), .ctrl_drop(cfg_ctrl),
        .is_bcast(is_bcast), .illegal(illegal), .resv_drop(resv_drop)
    );

    window_ticker #(.PERIOD(WINDOW_CYCLES)) u_tick (
        .clk(clk), .rst_n(rst_n), .tick(tick)
    );

    storm_counter #(.LIMIT(BURST_LIMIT)) u_storm (
        .clk(clk), .rst_n(rst_n), .frame_seen(frm_end && !illegal),
        .is_bcast(is_bcast), .tick(tick), .over_limit(over_limit)
    );

    // Pick the highest-priority drop cause for the current frame.
    always_comb begin
        if (illegal)                                   cause_d = CAUSE_ILLEGAL;
        else if (resv_drop)                            cause_d = CAUSE_RESERVED;
        else if (cfg_storm && is_bcast && over_limit)  cause_d = CAUSE_STORM;
        else                                           cause_d = CAUSE_NONE;
    end

    // Register the verdict one cycle after the frame-end strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            verdict_valid <= 1'b0;
            verdict_drop  <= 1'b0;
            verdict_cause <= 2'd0;
        end else begin
            verdict_valid <= frm_end;
            verdict_drop  <= frm_end && (cause_d != CAUSE_NONE);
            verdict_cause <= frm_end ? cause_d : CAUSE_NONE;
        end
    end

    p_verdict_follows_end_r1: assert property (@(posedge clk) disable iff (!rst_n)
        frm_end |=> verdict_valid);
    p_no_spurious_verdict_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !frm_end |=> !verdict_valid);
    p_fixed_resv_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_end && frm_crc_ok && frm_len == LEN_W'(100) &&
         (frm_da == 48'h0180_C200_0001 || frm_da == 48'h0180_C200_0002))
        |=> (verdict_drop && verdict_cause == 2'd2));
    p_bad_len_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_end && (frm_len < LEN_W'(MIN_LEN) || frm_len > LEN_W'(MAX_LEN)))
        |=> (verdict_drop && verdict_cause == 2'd1));
    p_no_storm_when_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (verdict_valid && !cfg_storm) |-> (verdict_cause != 2'd3));
    p_straps_held_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ($stable(cfg_storm) && $stable(cfg_ctrl) && $stable(cfg_accept)));
endmodule

// File: tb/ingress_frame_gate_tb.sv
module ingress_frame_gate_tb;
    localparam int unsigned WIN = 3000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        s_storm = 1'b0, s_ctrl = 1'b0, s_acc = 1'b0;
    logic        frm_end = 1'b0;
    logic [47:0] frm_da = '0;
    logic        frm_crc_ok = 1'b1;
    logic [11:0] frm_len = 12'd100;
    logic        verdict_valid, verdict_drop;
    logic [1:0]  verdict_cause;

    int checks = 0;
    int errors = 0;

    localparam logic [47:0] BC  = 48'hFFFF_FFFF_FFFF;
    localparam logic [47:0] UC  = 48'h0022_3344_5566;
    localparam logic [47:0] RSV = 48'h0180_C200_0000;

    always #10 clk = ~clk;

    ingress_frame_gate #(.WINDOW_CYCLES(WIN)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .strap_storm_en(s_storm), .strap_ctrl_drop(s_ctrl), .strap_accept_err(s_acc),
        .frm_end(frm_end), .frm_da(frm_da), .frm_crc_ok(frm_crc_ok), .frm_len(frm_len),
        .verdict_valid(verdict_valid), .verdict_drop(verdict_drop),
        .verdict_cause(verdict_cause)
    );

    task automatic check(input string req, input logic v, input logic d, input logic [1:0] c);
        checks++;
        if (verdict_valid !== v || verdict_drop !== d || verdict_cause !== c) begin
            errors++;
            $display("FAIL %s: got valid=%0b drop=%0b cause=%0d, expected valid=%0b drop=%0b cause=%0d",
                     req, verdict_valid, verdict_drop, verdict_cause, v, d, c);
        end
    endtask

    task automatic do_reset(input logic st, input logic ct, input logic ac);
        @(negedge clk);
        rst_n = 1'b0; s_storm = st; s_ctrl = ct; s_acc = ac; frm_end = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Drive one frame; verdict is sampled at the following falling edge.
    task automatic send(input logic [47:0] da, input logic ok, input logic [11:0] len,
                        input string req, input logic d, input logic [1:0] c);
        frm_da = da; frm_crc_ok = ok; frm_len = len; frm_end = 1'b1;
        @(negedge clk);
        frm_end = 1'b0;
        check(req, 1'b1, d, c);
        @(negedge clk);
    endtask

    task automatic t_reset;
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R12 during reset", 1'b0, 1'b0, 2'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R12 after release", 1'b0, 1'b0, 2'd0);
    endtask

    task automatic t_basic;
        do_reset(1'b1, 1'b0, 1'b0);
        send(UC, 1'b1, 12'd100, "R1 unicast forward", 1'b0, 2'd0);
        check("R1 no verdict without strobe", 1'b0, 1'b0, 2'd0);
    endtask

    task automatic t_storm;
        do_reset(1'b1, 1'b0, 1'b0);
        for (int i = 0; i < 64; i++) send(BC, 1'b1, 12'd64, "R2 within limit", 1'b0, 2'd0);
        send(BC, 1'b1, 12'd64, "R2 65th broadcast", 1'b1, 2'd3);
        send(BC, 1'b1, 12'd64, "R2 66th broadcast", 1'b1, 2'd3);
        send(UC, 1'b1, 12'd80, "R3 unicast passes", 1'b0, 2'd0);
        send(BC, 1'b1, 12'd64, "R3 run restarted", 1'b0, 2'd0);
        for (int i = 0; i < 63; i++) send(BC, 1'b1, 12'd64, "R2 refill", 1'b0, 2'd0);
        send(UC, 1'b0, 12'd80, "R10 bad crc unicast", 1'b1, 2'd1);
        send(UC, 1'b1, 12'd20, "R10 runt unicast", 1'b1, 2'd1);
        send(BC, 1'b1, 12'd64, "R10 illegal did not clear run", 1'b1, 2'd3);
        send(RSV | 48'h1, 1'b1, 12'd100, "R3 reserved frame dropped", 1'b1, 2'd2);
        send(BC, 1'b1, 12'd64, "R3 reserved frame cleared run", 1'b0, 2'd0);
    endtask

    task automatic t_window;
        do_reset(1'b1, 1'b0, 1'b0);
        for (int i = 0; i < 64; i++) send(BC, 1'b1, 12'd64, "R4 fill run", 1'b0, 2'd0);
        repeat (WIN) @(negedge clk);
        send(BC, 1'b1, 12'd64, "R4 window cleared run", 1'b0, 2'd0);
    endtask

    task automatic t_storm_off;
        do_reset(1'b0, 1'b0, 1'b0);
        for (int i = 0; i < 70; i++) send(BC, 1'b1, 12'd64, "R5 storm disabled", 1'b0, 2'd0);
    endtask

    task automatic t_reserved;
        do_reset(1'b0, 1'b0, 1'b0);
        send(RSV | 48'h01, 1'b1, 12'd100, "R6 addr 01", 1'b1, 2'd2);
        send(RSV | 48'h02, 1'b1, 12'd100, "R6 addr 02", 1'b1, 2'd2);
        send(RSV | 48'h03, 1'b1, 12'd100, "R7 addr 03 strap low", 1'b0, 2'd0);
        send(RSV | 48'h0F, 1'b1, 12'd100, "R7 addr 0F strap low", 1'b0, 2'd0);
        do_reset(1'b0, 1'b1, 1'b0);
        send(RSV | 48'h03, 1'b1, 12'd100, "R7 addr 03 strap high", 1'b1, 2'd2);
        send(RSV | 48'h0F, 1'b1, 12'd100, "R7 addr 0F strap high", 1'b1, 2'd2);
        send(RSV | 48'h00, 1'b1, 12'd100, "R7 addr 00 untouched", 1'b0, 2'd0);
        send(RSV | 48'h10, 1'b1, 12'd100, "R7 addr 10 untouched", 1'b0, 2'd0);
        send(RSV | 48'h01, 1'b1, 12'd100, "R6 addr 01 strap high", 1'b1, 2'd2);
    endtask

    task automatic t_illegal;
        do_reset(1'b0, 1'b0, 1'b0);
        send(UC, 1'b0, 12'd100, "R8 bad crc", 1'b1, 2'd1);
        send(UC, 1'b1, 12'd63, "R9 length 63", 1'b1, 2'd1);
        send(UC, 1'b1, 12'd64, "R9 length 64", 1'b0, 2'd0);
        send(UC, 1'b1, 12'd1536, "R9 length 1536", 1'b0, 2'd0);
        send(UC, 1'b1, 12'd1537, "R9 length 1537", 1'b1, 2'd1);
        send(RSV | 48'h01, 1'b0, 12'd100, "R10 illegal beats reserved", 1'b1, 2'd1);
        do_reset(1'b0, 1'b0, 1'b1);
        send(UC, 1'b0, 12'd100, "R8 bad crc accepted", 1'b0, 2'd0);
        send(UC, 1'b0, 12'd63, "R9 short despite accept", 1'b1, 2'd1);
        send(UC, 1'b0, 12'd1537, "R9 long despite accept", 1'b1, 2'd1);
    endtask

    task automatic t_strap_hold;
        do_reset(1'b0, 1'b1, 1'b0);
        s_ctrl = 1'b0; s_acc = 1'b1; s_storm = 1'b1;
        @(negedge clk);
        send(RSV | 48'h05, 1'b1, 12'd100, "R11 ctrl strap held", 1'b1, 2'd2);
        send(UC, 1'b0, 12'd100, "R11 accept strap held", 1'b1, 2'd1);
        for (int i = 0; i < 65; i++) send(BC, 1'b1, 12'd64, "R11 storm strap held", 1'b0, 2'd0);
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        t_reset();
        t_basic();
        t_storm();
        t_window();
        t_storm_off();
        t_reserved();
        t_illegal();
        t_strap_hold();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule